// File: doc/BRIEF.md
# Iterative multiply sequencer

This block sequences a multiply unit that reuses its array over several clock cycles while it occupies the execute stage. An operation is offered on `issue_valid` together with a class code, an accumulate bit, a set-flags bit, two word operands and a double-word addend. Once accepted, the operation loops through a number of execute iterations that depends on its class. During that time the block holds the issue stage off with `issue_stall`. It pulses `done` in the final iteration, which is the cycle in which the execute stage is given back.

The cycle in which the product may be forwarded is separate from the cycle in which the execute stage is freed, and it depends on the class. For double-word products, `lo_ready` marks the low word and `hi_ready` follows one cycle later. Flag-setting variants spend one more iteration after the value is ready; in that iteration `flag_we` carries N and Z computed over the full product. The product itself is a behavioural multiply-accumulate. Only its timing is modelled.

"Cycle k" below means the k-th clock period after the rising edge at which the operation was accepted. Iteration k occupies cycle k.

Top module: `mul_iter_seq`

## Requirements
- R1: A synchronous active-high reset abandons any operation in flight. In the cycle after a reset edge, `issue_stall`, `lo_ready`, `hi_ready`, `done` and `flag_we` are all low.
- R2: An operation is accepted at a rising edge where `issue_valid` is high and `issue_stall` is low. For an operation of N iterations, `issue_stall` is high in cycles 1 to N-1 and low in cycle N. `issue_valid` and the operation inputs are ignored while `issue_stall` is high.
- R3: `op_class` encoding and iteration counts: 0 = signed halfword multiply (1 iteration); 1 = halfword multiply with word accumulate (2); 2 = halfword multiply with double-word accumulate (2); 3 = word multiply (2, or 4 when flag-setting); 4 = unsigned long multiply and 5 = signed long multiply (3, or 5 when flag-setting). `done` is high only in cycle N.
- R4: The value-ready strobe `lo_ready` pulses for one cycle. Its cycle is 2 for classes 0, 1 and 2, 3 for class 3, and 3 for classes 4 and 5.
- R5: Double-word products (classes 2, 4 and 5) also pulse `hi_ready` exactly one cycle after `lo_ready`: in cycle 3 for class 2 and in cycle 4 for classes 4 and 5. Single-word products never raise `hi_ready`.
- R6: For flag-setting variants, the last iteration comes after the value is ready, and `flag_we` is high with `done`. In that cycle `flag_n` is the top bit of the product (bit 63 for double-word products, bit 31 otherwise), and `flag_z` is high when the product is zero. Non-flag-setting operations never raise `flag_we`.
- R7: `result` is valid whenever `lo_ready` or `hi_ready` is high. Class 0 gives the sign-extended 16x16 product of the low halves. Class 1 adds `acc_in[31:0]` to it, modulo 2^32. Class 2 adds the sign-extended product to `acc_in`, modulo 2^64. Class 3 gives `src_a*src_b` modulo 2^32, plus `acc_in[31:0]` when `op_acc` is set. Classes 4 and 5 give the full 64-bit unsigned or signed product, plus `acc_in` when `op_acc` is set.
- R8: `op_acc` and `op_setf` have no effect on classes 0, 1 and 2. Codes 6 and 7 behave exactly as class 3.
- R9: A new operation may be accepted in the `done` cycle of the previous one. When it is, a ready strobe that the older operation owes in the following cycle still appears in that cycle, carrying the older result.
- R10: Single-word products appear on `result[31:0]`, with `result[63:32]` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation offered this cycle |
| op_class | input | 3 | Operation class code |
| op_acc | input | 1 | Add `acc_in` (classes 3 to 5) |
| op_setf | input | 1 | Flag-setting variant (classes 3 to 5) |
| src_a | input | W | Multiplicand |
| src_b | input | W | Multiplier |
| acc_in | input | 2W | Addend |
| issue_stall | output | 1 | Issue stage must hold |
| lo_ready | output | 1 | Value (or its low word) may be forwarded |
| hi_ready | output | 1 | High word may be forwarded |
| result | output | 2W | Product, valid with a ready strobe |
| done | output | 1 | Final execute iteration |
| flag_we | output | 1 | Flag update, with `done` |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
A miscounted iteration register shows at the ports within the operation's own window. `done` and the fall of `issue_stall` move off cycle N, and the next issue is accepted early or late. A strobe taken from a wrong compare point moves `lo_ready`, `hi_ready` or `flag_we` by a cycle against the per-class table, and this is seen no later than cycle N+1. A corrupted hand-over register appears only in the first cycle of a back-to-back successor, as a missing, extra or stale-valued strobe. For that reason the sweep mixes zero-gap issue with idle gaps and drives junk requests while the stage is stalled.

// File: rtl/mulseq_pkg.sv
`timescale 1ns/1ps
package mulseq_pkg;

    typedef enum logic [2:0] {
        CLS_HALF      = 3'd0,
        CLS_HALF_ACC  = 3'd1,
        CLS_HALF_LACC = 3'd2,
        CLS_WORD      = 3'd3,
        CLS_LONG_U    = 3'd4,
        CLS_LONG_S    = 3'd5,
        CLS_RSV6      = 3'd6,
        CLS_RSV7      = 3'd7
    } mul_cls_e;

    // execute iterations per class
    localparam int ITER_HALF     = 1;
    localparam int ITER_HALF_ACC = 2;
    localparam int ITER_WORD     = 2;
    localparam int ITER_WORD_F   = 4;
    localparam int ITER_LONG     = 3;
    localparam int ITER_LONG_F   = 5;
    // cycle (counted from acceptance) in which the value / low word is ready
    localparam int RDY_HALF      = 2;
    localparam int RDY_HALF_ACC  = 2;
    localparam int RDY_WORD      = 3;
    localparam int RDY_LONG_LO   = 3;

    localparam int CNT_W = $clog2(ITER_LONG_F + 2);
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t n_iter;
        cnt_t lo_at;
        cnt_t hi_at;
        logic wide;
        logic setf;
    } timing_t;

    function automatic mul_cls_e norm_cls(logic [2:0] code);
        mul_cls_e c;
        c = mul_cls_e'(code);
        if (c == CLS_RSV6 || c == CLS_RSV7) c = CLS_WORD;
        return c;
    endfunction

    function automatic logic takes_mods(mul_cls_e c);
        return (c == CLS_WORD) || (c == CLS_LONG_U) || (c == CLS_LONG_S);
    endfunction

    function automatic timing_t timing_of(mul_cls_e c, logic sf);
        timing_t t;
        t = '0;
        case (c)
            CLS_HALF: begin
                t.n_iter = cnt_t'(ITER_HALF);
                t.lo_at  = cnt_t'(RDY_HALF);
            end
            CLS_HALF_ACC: begin
                t.n_iter = cnt_t'(ITER_HALF_ACC);
                t.lo_at  = cnt_t'(RDY_HALF_ACC);
            end
            CLS_HALF_LACC: begin
                t.n_iter = cnt_t'(ITER_HALF_ACC);
                t.lo_at  = cnt_t'(RDY_HALF_ACC);
                t.hi_at  = cnt_t'(RDY_HALF_ACC + 1);
                t.wide   = 1'b1;
            end
            CLS_LONG_U, CLS_LONG_S: begin
                t.n_iter = sf ? cnt_t'(ITER_LONG_F) : cnt_t'(ITER_LONG);
                t.lo_at  = cnt_t'(RDY_LONG_LO);
                t.hi_at  = cnt_t'(RDY_LONG_LO + 1);
                t.wide   = 1'b1;
                t.setf   = sf;
            end
            default: begin
                t.n_iter = sf ? cnt_t'(ITER_WORD_F) : cnt_t'(ITER_WORD);
                t.lo_at  = cnt_t'(RDY_WORD);
                t.setf   = sf;
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/mulseq_decode.sv
`timescale 1ns/1ps
module mulseq_decode
    import mulseq_pkg::*;
(
    input  logic [2:0] op_class,
    input  logic       op_acc,
    input  logic       op_setf,
    output mul_cls_e   cls,
    output logic       acc_en,
    output timing_t    tm
);
    logic mods_ok;

    always_comb begin
        cls     = norm_cls(op_class);
        mods_ok = takes_mods(cls);
        acc_en  = op_acc & mods_ok;
        tm      = timing_of(cls, op_setf & mods_ok);
    end
endmodule

// File: rtl/mulseq_arith.sv
`timescale 1ns/1ps
module mulseq_arith
    import mulseq_pkg::*;
#(
    parameter int W = 32
) (
    input  mul_cls_e         cls,
    input  logic             acc_en,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [2*W-1:0]   acc,
    output logic [2*W-1:0]   res
);
    localparam int H = W / 2;
    localparam int R = 2 * W;

    logic [W-1:0] half_p;
    logic [W-1:0] word_p;
    logic [R-1:0] long_u;
    logic [R-1:0] long_s;
    logic [W-1:0] acc_lo;
    logic [R-1:0] acc_full;

    always_comb begin
        half_p   = {{H{a[H-1]}}, a[H-1:0]} * {{H{b[H-1]}}, b[H-1:0]};
        word_p   = a * b;
        long_u   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        long_s   = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
        acc_lo   = acc_en ? acc[W-1:0] : '0;
        acc_full = acc_en ? acc : '0;
        case (cls)
            CLS_HALF:      res = {{W{1'b0}}, half_p};
            CLS_HALF_ACC:  res = {{W{1'b0}}, half_p + acc[W-1:0]};
            CLS_HALF_LACC: res = {{W{half_p[W-1]}}, half_p} + acc;
            CLS_LONG_U:    res = long_u + acc_full;
            CLS_LONG_S:    res = long_s + acc_full;
            default:       res = {{W{1'b0}}, word_p + acc_lo};
        endcase
    end
endmodule

// File: rtl/mulseq_ctrl.sv
`timescale 1ns/1ps
module mulseq_ctrl
    import mulseq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  timing_t          tm_in,
    input  logic [2*W-1:0]   res_in,
    output logic             issue_stall,
    output logic             lo_ready,
    output logic             hi_ready,
    output logic [2*W-1:0]   result,
    output logic             done,
    output logic             flag_we,
    output logic             flag_n,
    output logic             flag_z
);
    localparam int R = 2 * W;

    logic         busy_q;
    cnt_t         iter_q;
    timing_t      tm_q;
    logic [R-1:0] res_q;
    logic         tail_lo_q;
    logic         tail_hi_q;
    logic [R-1:0] tail_res_q;

    logic last_it;
    logic accept;
    logic act_lo;
    logic act_hi;
    cnt_t after_last;

    always_comb begin
        last_it     = busy_q && (iter_q == tm_q.n_iter);
        issue_stall = busy_q && !last_it;
        accept      = issue_valid && !issue_stall;
        after_last  = tm_q.n_iter + cnt_t'(1);
        act_lo      = busy_q && (iter_q == tm_q.lo_at);
        act_hi      = busy_q && tm_q.wide && (iter_q == tm_q.hi_at);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            iter_q     <= '0;
            tm_q       <= '0;
            res_q      <= '0;
            tail_lo_q  <= 1'b0;
            tail_hi_q  <= 1'b0;
            tail_res_q <= '0;
        end else begin
            if (accept) begin
                busy_q <= 1'b1;
                iter_q <= cnt_t'(1);
                tm_q   <= tm_in;
                res_q  <= res_in;
            end else if (last_it) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                iter_q <= iter_q + cnt_t'(1);
            end
            // strobes owed one cycle past the final iteration move to the tail
            tail_lo_q <= last_it && (tm_q.lo_at == after_last);
            tail_hi_q <= last_it && tm_q.wide && (tm_q.hi_at == after_last);
            if (last_it) tail_res_q <= res_q;
        end
    end

    always_comb begin
        lo_ready = act_lo || tail_lo_q;
        hi_ready = act_hi || tail_hi_q;
        result   = (tail_lo_q || tail_hi_q) ? tail_res_q : res_q;
        done     = last_it;
        flag_we  = last_it && tm_q.setf;
        flag_n   = tm_q.wide ? res_q[R-1] : res_q[W-1];
        flag_z   = (res_q == '0);
    end
endmodule

// File: rtl/mul_iter_seq.sv
`timescale 1ns/1ps
module mul_iter_seq
    import mulseq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [2:0]       op_class,
    input  logic             op_acc,
    input  logic             op_setf,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [2*W-1:0]   acc_in,
    output logic             issue_stall,
    output logic             lo_ready,
    output logic             hi_ready,
    output logic [2*W-1:0]   result,
    output logic             done,
    output logic             flag_we,
    output logic             flag_n,
    output logic             flag_z
);
    mul_cls_e       dec_cls;
    logic           dec_acc;
    timing_t        dec_tm;
    logic [2*W-1:0] new_res;

    mulseq_decode u_decode (
        .op_class (op_class),
        .op_acc   (op_acc),
        .op_setf  (op_setf),
        .cls      (dec_cls),
        .acc_en   (dec_acc),
        .tm       (dec_tm)
    );

    mulseq_arith #(.W(W)) u_arith (
        .cls    (dec_cls),
        .acc_en (dec_acc),
        .a      (src_a),
        .b      (src_b),
        .acc    (acc_in),
        .res    (new_res)
    );

    mulseq_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .tm_in       (dec_tm),
        .res_in      (new_res),
        .issue_stall (issue_stall),
        .lo_ready    (lo_ready),
        .hi_ready    (hi_ready),
        .result      (result),
        .done        (done),
        .flag_we     (flag_we),
        .flag_n      (flag_n),
        .flag_z      (flag_z)
    );
endmodule

// File: rtl/mul_iter_seq_chk.sv
`timescale 1ns/1ps
module mul_iter_seq_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           issue_valid,
    input logic           issue_stall,
    input logic           lo_ready,
    input logic           hi_ready,
    input logic [2*W-1:0] result,
    input logic           done,
    input logic           flag_we,
    input logic           flag_z
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!issue_stall && !lo_ready && !hi_ready && !done && !flag_we));

    assert_stall_ends_in_done_R2: assert property (@(posedge clk) disable iff (rst)
        issue_stall |=> (issue_stall || done));

    assert_no_value_in_first_iter_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !issue_stall && !done) |=> (!lo_ready && !hi_ready));

    assert_high_follows_low_R5: assert property (@(posedge clk) disable iff (rst)
        hi_ready |-> $past(lo_ready));

    assert_flag_iter_after_value_R6: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> $past(lo_ready || hi_ready));

    assert_zero_flag_matches_R6: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> (flag_z == (result == '0)));
endmodule

bind mul_iter_seq mul_iter_seq_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_stall (issue_stall),
    .lo_ready    (lo_ready),
    .hi_ready    (hi_ready),
    .result      (result),
    .done        (done),
    .flag_we     (flag_we),
    .flag_z      (flag_z)
);

// File: tb/test_mul_iter_seq.sv
`timescale 1ns/1ps
module test_mul_iter_seq;
    localparam int NOPS = 96;
    localparam int MAXC = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [2:0]  op_class = '0;
    logic        op_acc = 1'b0;
    logic        op_setf = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [63:0] acc_in = '0;
    logic        issue_stall, lo_ready, hi_ready, done, flag_we, flag_n, flag_z;
    logic [63:0] result;

    always #2.5 clk = ~clk;

    mul_iter_seq #(.W(32)) i_mul_iter_seq (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .op_class(op_class),
        .op_acc(op_acc), .op_setf(op_setf), .src_a(src_a), .src_b(src_b),
        .acc_in(acc_in), .issue_stall(issue_stall), .lo_ready(lo_ready),
        .hi_ready(hi_ready), .result(result), .done(done), .flag_we(flag_we),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // operation list
    logic [2:0]  o_cls [NOPS];
    bit          o_acc [NOPS];
    bit          o_sf  [NOPS];
    logic [31:0] o_a   [NOPS];
    logic [31:0] o_b   [NOPS];
    logic [63:0] o_c   [NOPS];
    int          o_gap [NOPS];

    // expected per-cycle behaviour
    bit          e_stall [MAXC];
    bit          e_done  [MAXC];
    bit          e_lo    [MAXC];
    bit          e_hi    [MAXC];
    bit          e_we    [MAXC];
    bit          e_n     [MAXC];
    bit          e_z     [MAXC];
    bit          e_b2b   [MAXC];
    logic [63:0] e_res   [MAXC];
    string       e_tag   [MAXC];
    int          e_op    [MAXC];

    function automatic logic [63:0] model_res(input logic [2:0] c, input bit acc,
                                              input logic [31:0] a, input logic [31:0] b,
                                              input logic [63:0] ad);
        logic signed [63:0] hp;
        logic signed [63:0] sp;
        logic [63:0] up;
        hp = $signed(a[15:0]) * $signed(b[15:0]);
        sp = $signed(a) * $signed(b);
        up = {32'b0, a} * {32'b0, b};
        case (c)
            3'd0: return {32'b0, hp[31:0]};
            3'd1: return {32'b0, hp[31:0] + ad[31:0]};
            3'd2: return hp + ad;
            3'd4: return up + (acc ? ad : 64'd0);
            3'd5: return sp + (acc ? ad : 64'd0);
            default: return {32'b0, a * b + (acc ? ad[31:0] : 32'd0)};
        endcase
    endfunction

    initial begin
        int seed;
        int prev_a, prev_n, prev_tail;
        // build a sweep: every class code x accumulate x set-flags x 3 operand sets
        seed = 32'h1234_5678;
        for (int k = 0; k < NOPS; k++) begin
            o_cls[k] = 3'(k % 8);
            o_acc[k] = ((k / 8) % 2) == 1;
            o_sf[k]  = ((k / 16) % 2) == 1;
            case (k / 32)
                0: begin o_a[k] = 32'd0; o_b[k] = 32'h1234_5678; o_c[k] = 64'd0; end
                1: begin o_a[k] = 32'hFFFF_8000; o_b[k] = 32'h0000_7FFF; o_c[k] = 64'h8000_0000_0000_0001; end
                default: begin
                    seed = seed * 1103515245 + 12345; o_a[k] = seed;
                    seed = seed * 1103515245 + 12345; o_b[k] = seed;
                    seed = seed * 1103515245 + 12345; o_c[k][63:32] = seed;
                    seed = seed * 1103515245 + 12345; o_c[k][31:0] = seed;
                end
            endcase
            o_gap[k] = (k * 7) % 3;
        end
        for (int j = 0; j < MAXC; j++) begin
            e_stall[j] = 0; e_done[j] = 0; e_lo[j] = 0; e_hi[j] = 0; e_we[j] = 0;
            e_n[j] = 0; e_z[j] = 0; e_b2b[j] = 0; e_res[j] = '0; e_tag[j] = ""; e_op[j] = -1;
        end
        prev_a = 0; prev_n = 0; prev_tail = -1;
        for (int k = 0; k < NOPS; k++) begin
            logic [2:0] cn;
            bit sfe, wide;
            int acc_t, n, lo, hi;
            logic [63:0] r;
            string tag;
            acc_t = (k == 0) ? 1 : prev_a + prev_n + o_gap[k];
            cn  = (o_cls[k] >= 3'd6) ? 3'd3 : o_cls[k];
            sfe = o_sf[k] && (cn >= 3'd3);
            wide = (cn == 3'd2) || (cn == 3'd4) || (cn == 3'd5);
            hi = 0;
            case (cn)
                3'd0: begin n = 1; lo = 2; end
                3'd1: begin n = 2; lo = 2; end
                3'd2: begin n = 2; lo = 2; hi = 3; end
                3'd3: begin n = sfe ? 4 : 2; lo = 3; end
                default: begin n = sfe ? 5 : 3; lo = 3; hi = 4; end
            endcase
            if (prev_tail == acc_t + 1) e_b2b[prev_tail] = 1;  // R9 hand-over cycle
            r = model_res(cn, o_acc[k] && (cn >= 3'd3), o_a[k], o_b[k], o_c[k]);
            tag = wide ? "R5 R7" : "R7 R10";
            if (o_cls[k] >= 3'd6 || (o_cls[k] <= 3'd2 && (o_acc[k] || o_sf[k]))) tag = {tag, " R8"};
            e_op[acc_t] = k;
            for (int i = 1; i < n; i++) e_stall[acc_t + i] = 1;
            e_done[acc_t + n] = 1;
            e_lo[acc_t + lo] = 1; e_res[acc_t + lo] = r; e_tag[acc_t + lo] = tag;
            if (hi != 0) begin e_hi[acc_t + hi] = 1; e_res[acc_t + hi] = r; e_tag[acc_t + hi] = tag; end
            if (sfe) begin
                e_we[acc_t + n] = 1;
                e_n[acc_t + n] = wide ? r[63] : r[31];
                e_z[acc_t + n] = (r == 64'd0);
            end
            prev_tail = (lo == n + 1 || hi == n + 1) ? acc_t + n + 1 : -1;
            prev_a = acc_t; prev_n = n;
        end

        // reset phase
        repeat (3) @(negedge clk);
        chk(!issue_stall && !lo_ready && !hi_ready && !done && !flag_we, "R1 reset idle",
            {59'd0, issue_stall, lo_ready, hi_ready, done, flag_we}, 64'd0);
        rst = 1'b0;

        // main sweep
        for (int j = 0; j < prev_a + prev_n + 3; j++) begin
            @(negedge clk);
            chk(issue_stall === e_stall[j], "R2 stall", 64'(issue_stall), 64'(e_stall[j]));
            chk(done === e_done[j], "R3 done", 64'(done), 64'(e_done[j]));
            chk(lo_ready === e_lo[j], e_b2b[j] ? "R4 R9 lo_ready" : "R4 lo_ready", 64'(lo_ready), 64'(e_lo[j]));
            chk(hi_ready === e_hi[j], e_b2b[j] ? "R5 R9 hi_ready" : "R5 hi_ready", 64'(hi_ready), 64'(e_hi[j]));
            chk(flag_we === e_we[j], "R6 R8 flag_we", 64'(flag_we), 64'(e_we[j]));
            if (e_lo[j] || e_hi[j])
                chk(result === e_res[j], e_tag[j], result, e_res[j]);
            if (e_we[j])
                chk({flag_n, flag_z} === {e_n[j], e_z[j]}, "R6 flags",
                    64'({flag_n, flag_z}), 64'({e_n[j], e_z[j]}));
            if (e_op[j] >= 0) begin
                int k;
                k = e_op[j];
                issue_valid = 1'b1; op_class = o_cls[k]; op_acc = o_acc[k]; op_setf = o_sf[k];
                src_a = o_a[k]; src_b = o_b[k]; acc_in = o_c[k];
            end else if (e_stall[j]) begin
                // junk request while stalled: must be ignored (R2)
                issue_valid = 1'b1; op_class = 3'd0; op_acc = 1'b1; op_setf = 1'b1;
                src_a = 32'hDEAD_BEEF; src_b = 32'h0BAD_F00D; acc_in = 64'hFFFF_FFFF_FFFF_FFFF;
            end else begin
                issue_valid = 1'b0;
            end
        end

        // reset in the middle of a flag-setting long multiply (R1)
        @(negedge clk);
        issue_valid = 1'b1; op_class = 3'd4; op_acc = 1'b0; op_setf = 1'b1;
        src_a = 32'd7; src_b = 32'd9; acc_in = '0;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(issue_stall === 1'b1, "R2 stall in long op", 64'(issue_stall), 64'd1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!issue_stall && !lo_ready && !hi_ready && !done && !flag_we, "R1 mid-run reset",
            {59'd0, issue_stall, lo_ready, hi_ready, done, flag_we}, 64'd0);
        rst = 1'b0;
        issue_valid = 1'b1; op_class = 3'd0; src_a = 32'd3; src_b = 32'd5;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(done === 1'b1 && issue_stall === 1'b0, "R1 R3 first op after reset",
            {62'd0, done, issue_stall}, 64'd2);
        @(negedge clk);
        chk(lo_ready === 1'b1, "R1 R4 ready after reset", 64'(lo_ready), 64'd1);
        chk(result === 64'd15, "R1 R7 result after reset", result, 64'd15);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule